// File: doc/BRIEF.md
# Full-Bridge Gate Timing Sequencer

This block generates the six gate-control levels for a four-switch bridge converter: two high-side switches, two low-side switches and two output synchronous rectifiers. The high-side pair is never modulated. It alternates at exactly half duty, and each high side conducts for one whole half-cycle of `HALF_CYC` system clocks. During each half-cycle the low-side switch on the leg whose high side is off gives the power pulse. That pulse starts a programmable resonant delay into the half-cycle. It stops one clock after a digital peak-current trip is seen, or at a duty ceiling if no trip comes first.

The trip input comes from an external comparator. For a programmable number of cycles at the start of each pulse it is simply not looked at, so switching spikes cannot end the pulse. The duty ceiling always leaves a programmable dead time between a low-side turn-off and the turn-on of the high side on the same leg. Each synchronous-rectifier output is released while its half-cycle's low-side switch conducts, and it comes back on a dead time after that switch opens.

All three timing values are counted in system clocks. They are taken in once, when a half-cycle begins. Every output passes through one register stage, so the six levels change together on a clock edge. These control pins are plain levels: there is no data stream and no handshake.

Top module: `bridge_gate_seq`

## Requirements
- R1: A synchronous reset drives `hs_a`, `hs_b`, `ls_a`, `ls_b`, `sr_0` and `sr_1` low from the clock edge that samples it. When the block next runs, it starts with half-cycle 0.
- R2: With `run` high, `hs_a` is high for the whole of half-cycle 0 and `hs_b` for the whole of half-cycle 1. Each half-cycle lasts `HALF_CYC` clocks, the two halves alternate, and both are never high together. The outputs follow the internal half-cycle timing with one clock of latency.
- R3: `hs_a` and `ls_a` are never high together, and neither are `hs_b` and `ls_b`, for any setting or trip timing.
- R4: `ls_b` pulses only in half-cycle 0 and `ls_a` only in half-cycle 1. A pulse rises `res_dly` clocks after its half-cycle starts. If `res_dly` is not below the duty ceiling, no pulse occurs.
- R5: If `trip` is sampled high while a pulse is on and the blanking window is over, the low-side output falls one clock after the edge that sampled it. It stays low for the rest of that half-cycle.
- R6: `trip` has no effect during the first `blank_len` clocks of a pulse.
- R7: Without a trip, a pulse ends at the duty ceiling. At that point `HALF_CYC - dead_len` clocks of the half-cycle have elapsed.
- R8: After a low-side output falls, at least `dead_len` clocks pass before the high side of the same leg rises.
- R9: `sr_0` belongs to half-cycle 0 and `sr_1` to half-cycle 1. Each is high while running, except from the start of its half's pulse until `dead_len` clocks after that pulse ends.
- R10: `res_dly`, `blank_len` and `dead_len` are captured only when a half-cycle begins. Changes made during a half-cycle take effect from the next one.
- R11: Dropping `run` takes all six outputs low two edges later. Raising it again starts at half-cycle 0, with `hs_a` high two edges after `run` is sampled high.
- R12: A `trip` sampled outside a pulse has no effect, and a trip affects only the half-cycle in which it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Switching enable; low holds the bridge off |
| trip | input | 1 | Peak-current trip flag from the comparator |
| res_dly | input | CW | Resonant delay in clocks |
| blank_len | input | CW | Trip blanking length in clocks |
| dead_len | input | CW | Dead time in clocks |
| hs_a | output | 1 | High side, leg A |
| hs_b | output | 1 | High side, leg B |
| ls_a | output | 1 | Low side, leg A |
| ls_b | output | 1 | Low side, leg B |
| sr_0 | output | 1 | Synchronous rectifier, half-cycle 0 |
| sr_1 | output | 1 | Synchronous rectifier, half-cycle 1 |

## Verification
A half-cycle counter off by one shows up on the high-side pair within one half-cycle, as a phase of the wrong length. A latched timing value that is wrong, or a missed reload, moves the low-side edges and the rectifier release in the first pulse that uses it. A trip flag that gets stuck, or is cleared at the wrong time, cuts or stretches the next pulse by whole cycles. Because the reference model is compared on every clock, each of these faults is reported at the first edge where the gate pattern differs.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

  typedef enum logic {
    HALF_0 = 1'b0,
    HALF_1 = 1'b1
  } half_t;

  typedef struct packed {
    logic hs_a;
    logic hs_b;
    logic ls_a;
    logic ls_b;
    logic sr_0;
    logic sr_1;
  } gates_t;

endpackage

// File: rtl/bgs_half_timer.sv
module bgs_half_timer
  import bgs_pkg::*;
#(
  parameter int HALF_CYC = 16,
  parameter int CW = $clog2(HALF_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] res_i,
  input  logic [CW-1:0] blank_i,
  input  logic [CW-1:0] dead_i,
  output logic          running,
  output half_t         phase,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic [CW-1:0] res_q,
  output logic [CW-1:0] blank_q,
  output logic [CW-1:0] dead_q
);

  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  assign wrap = running && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      phase   <= HALF_0;
      cnt     <= '0;
      res_q   <= '0;
      blank_q <= '0;
      dead_q  <= '0;
    end else if (!run) begin
      running <= 1'b0;
      phase   <= HALF_0;
      cnt     <= '0;
    end else if (!running || wrap) begin
      running <= 1'b1;
      phase   <= (running && phase == HALF_0) ? HALF_1 : HALF_0;
      cnt     <= '0;
      res_q   <= res_i;
      blank_q <= blank_i;
      dead_q  <= dead_i;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bgs_lowside_ctrl.sv
module bgs_lowside_ctrl #(
  parameter int HALF_CYC = 16,
  parameter int CW = $clog2(HALF_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          running,
  input  logic          wrap,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] res_q,
  input  logic [CW-1:0] blank_q,
  input  logic [CW-1:0] dead_q,
  input  logic          trip,
  output logic          pulse_on,
  output logic          hold_on
);

  localparam int SW = CW + 1;
  localparam logic [SW-1:0] HALF_W = SW'(HALF_CYC);

  logic [SW-1:0] cnt_w;
  logic [SW-1:0] ceiling;
  logic [SW-1:0] blank_end;
  logic          tripped;
  logic          trip_live;
  logic [CW-1:0] gap;

  assign cnt_w     = {1'b0, cnt};
  assign ceiling   = HALF_W - {1'b0, dead_q};
  assign blank_end = {1'b0, res_q} + {1'b0, blank_q};

  assign pulse_on  = running && (cnt >= res_q) && (cnt_w < ceiling) && !tripped;
  assign trip_live = pulse_on && trip && (cnt_w >= blank_end);
  assign hold_on   = (gap != '0);

  always_ff @(posedge clk) begin
    if (rst || !run || !running || wrap) begin
      tripped <= 1'b0;
    end else if (trip_live) begin
      tripped <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run || !running) begin
      gap <= '0;
    end else if (pulse_on) begin
      gap <= dead_q;
    end else if (gap != '0) begin
      gap <= gap - 1'b1;
    end
  end

endmodule

// File: rtl/bgs_gate_stage.sv
module bgs_gate_stage
  import bgs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   running,
  input  half_t  phase,
  input  logic   pulse_on,
  input  logic   hold_on,
  output gates_t gates
);

  logic [1:0] hs_d;
  logic [1:0] ls_d;
  logic [1:0] sr_d;
  gates_t     nxt;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic mine;
    assign mine = running && (phase == half_t'(h));
    assign hs_d[h] = mine;
    assign ls_d[1-h] = mine && pulse_on;
    assign sr_d[h] = running && !(mine && (pulse_on || hold_on));
  end

  always_comb begin
    nxt.hs_a = hs_d[0];
    nxt.hs_b = hs_d[1];
    nxt.ls_a = ls_d[0];
    nxt.ls_b = ls_d[1];
    nxt.sr_0 = sr_d[0];
    nxt.sr_1 = sr_d[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gates <= '0;
    end else begin
      gates <= nxt;
    end
  end

endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
  import bgs_pkg::*;
#(
  parameter int HALF_CYC = 16,
  parameter int CW = $clog2(HALF_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          trip,
  input  logic [CW-1:0] res_dly,
  input  logic [CW-1:0] blank_len,
  input  logic [CW-1:0] dead_len,
  output logic          hs_a,
  output logic          hs_b,
  output logic          ls_a,
  output logic          ls_b,
  output logic          sr_0,
  output logic          sr_1
);

  logic          running;
  half_t         phase;
  logic [CW-1:0] cnt;
  logic          wrap;
  logic [CW-1:0] res_q;
  logic [CW-1:0] blank_q;
  logic [CW-1:0] dead_q;
  logic          pulse_on;
  logic          hold_on;
  gates_t        gates;

  bgs_half_timer #(.HALF_CYC(HALF_CYC), .CW(CW)) u_timer (
    .clk(clk), .rst(rst), .run(run),
    .res_i(res_dly), .blank_i(blank_len), .dead_i(dead_len),
    .running(running), .phase(phase), .cnt(cnt), .wrap(wrap),
    .res_q(res_q), .blank_q(blank_q), .dead_q(dead_q)
  );

  bgs_lowside_ctrl #(.HALF_CYC(HALF_CYC), .CW(CW)) u_lowside (
    .clk(clk), .rst(rst), .run(run), .running(running), .wrap(wrap),
    .cnt(cnt), .res_q(res_q), .blank_q(blank_q), .dead_q(dead_q),
    .trip(trip), .pulse_on(pulse_on), .hold_on(hold_on)
  );

  bgs_gate_stage u_gates (
    .clk(clk), .rst(rst), .running(running), .phase(phase),
    .pulse_on(pulse_on), .hold_on(hold_on), .gates(gates)
  );

  assign hs_a = gates.hs_a;
  assign hs_b = gates.hs_b;
  assign ls_a = gates.ls_a;
  assign ls_b = gates.ls_b;
  assign sr_0 = gates.sr_0;
  assign sr_1 = gates.sr_1;

endmodule

// File: rtl/bgs_checker.sv
module bgs_checker (
  input logic clk,
  input logic rst,
  input logic run,
  input logic hs_a,
  input logic hs_b,
  input logic ls_a,
  input logic ls_b,
  input logic sr_0,
  input logic sr_1
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(hs_a || hs_b || ls_a || ls_b || sr_0 || sr_1)); // R1

  AST_HIGH_PAIR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(hs_a && hs_b)); // R2

  AST_LEG_A_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
    !(hs_a && ls_a)); // R3

  AST_LEG_B_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
    !(hs_b && ls_b)); // R3

  AST_LS_B_IN_HALF0: assert property (@(posedge clk) disable iff (rst)
    ls_b |-> hs_a); // R4

  AST_LS_A_IN_HALF1: assert property (@(posedge clk) disable iff (rst)
    ls_a |-> hs_b); // R4

  AST_SR0_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ls_b |-> !sr_0); // R9

  AST_SR1_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ls_a |-> !sr_1); // R9

  AST_STOP_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$past(run, 2) |-> !(hs_a || hs_b || ls_a || ls_b || sr_0 || sr_1)); // R11

endmodule

bind bridge_gate_seq bgs_checker u_bgs_checker (
  .clk(clk), .rst(rst), .run(run),
  .hs_a(hs_a), .hs_b(hs_b), .ls_a(ls_a), .ls_b(ls_b),
  .sr_0(sr_0), .sr_1(sr_1)
);

// File: tb/bridge_gate_seq_test.sv
module bridge_gate_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 16;
  localparam int CW = $clog2(HALF);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic trip = 1'b0;
  logic [CW-1:0] res_dly = 4'd2;
  logic [CW-1:0] blank_len = 4'd3;
  logic [CW-1:0] dead_len = 4'd3;
  logic hs_a, hs_b, ls_a, ls_b, sr_0, sr_1;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_on = 0, m_cnt = 0, m_ph = 0, m_rd = 0, m_bl = 0, m_dt = 0, m_stop = HALF;
  bit e_hsa, e_hsb, e_lsa, e_lsb, e_sr0, e_sr1;

  // dead-time observer
  bit r8_watch = 1'b0;
  bit prev_lsb = 1'b0;
  bit counting = 1'b0;
  int gapcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_gate_seq #(.HALF_CYC(HALF)) uut (
    .clk(clk), .rst(rst), .run(run), .trip(trip),
    .res_dly(res_dly), .blank_len(blank_len), .dead_len(dead_len),
    .hs_a(hs_a), .hs_b(hs_b), .ls_a(ls_a), .ls_b(ls_b),
    .sr_0(sr_0), .sr_1(sr_1)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int fin;
    bit lo, srlow;
    fin = (HALF - m_dt < m_stop) ? HALF - m_dt : m_stop;
    lo = (m_on != 0) && m_cnt >= m_rd && m_cnt < fin;
    srlow = (m_on != 0) && (m_rd < fin) && m_cnt >= m_rd && m_cnt < fin + m_dt;
    if (rst) begin
      {e_hsa, e_hsb, e_lsa, e_lsb, e_sr0, e_sr1} = '0;
    end else begin
      e_hsa = (m_on != 0) && m_ph == 0;
      e_hsb = (m_on != 0) && m_ph == 1;
      e_lsb = lo && m_ph == 0;
      e_lsa = lo && m_ph == 1;
      e_sr0 = (m_on != 0) && !(m_ph == 0 && srlow);
      e_sr1 = (m_on != 0) && !(m_ph == 1 && srlow);
    end
    if (rst) begin
      m_on = 0; m_cnt = 0; m_ph = 0; m_rd = 0; m_bl = 0; m_dt = 0; m_stop = HALF;
    end else if (!run) begin
      m_on = 0; m_cnt = 0; m_ph = 0; m_stop = HALF;
    end else if (m_on == 0) begin
      m_on = 1; m_cnt = 0; m_ph = 0; m_stop = HALF;
      m_rd = res_dly; m_bl = blank_len; m_dt = dead_len;
    end else begin
      if (lo && trip && m_cnt >= m_rd + m_bl) m_stop = m_cnt + 1;
      if (m_cnt == HALF - 1) begin
        m_cnt = 0; m_ph = 1 - m_ph; m_stop = HALF;
        m_rd = res_dly; m_bl = blank_len; m_dt = dead_len;
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "hs_a", hs_a, e_hsa);
      check(cur_req, "hs_b", hs_b, e_hsb);
      check(cur_req, "ls_a", ls_a, e_lsa);
      check(cur_req, "ls_b", ls_b, e_lsb);
      check(cur_req, "sr_0", sr_0, e_sr0);
      check(cur_req, "sr_1", sr_1, e_sr1);
      check("R3", "same-leg overlap", int'((hs_a && ls_a) || (hs_b && ls_b)), 0);
      if (r8_watch) begin
        if (prev_lsb && !ls_b) begin counting = 1'b1; gapcnt = 0; end
        if (counting) begin
          if (hs_b) begin
            check("R8", "dead gap >= dead_len", int'(gapcnt >= int'(dead_len)), 1);
            counting = 1'b0;
          end else begin
            gapcnt++;
          end
        end
      end
      prev_lsb = ls_b;
    end
  end

  task automatic wait_cnt(input int c);
    do @(negedge clk); while (!(m_on != 0 && m_cnt == c));
  endtask

  task automatic trip_once;
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    check("R1", "outputs in reset", int'({hs_a, hs_b, ls_a, ls_b, sr_0, sr_1}), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2/R4/R7/R9/R8: free running, no trip
    cur_req = "R2/R4/R7/R9";
    r8_watch = 1'b1;
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11", "hs_a two edges after run", int'(hs_a), 1);
    repeat (4 * HALF) @(negedge clk);

    // R6: trip inside blanking ignored
    cur_req = "R6";
    wait_cnt(3);
    trip_once;
    @(negedge clk);
    check("R6", "pulse survives blanked trip", int'(ls_a || ls_b), 1);

    // R5: trip after blanking cuts the pulse
    cur_req = "R5";
    wait_cnt(7);
    trip_once;
    @(negedge clk);
    check("R5", "pulse ends after trip", int'(ls_a || ls_b), 0);
    wait_cnt(4);
    check("R12", "next pulse unaffected", int'(ls_a || ls_b), 1);

    // R12: trip outside the pulse
    cur_req = "R12";
    wait_cnt(0);
    trip_once;
    wait_cnt(14);
    trip_once;
    repeat (2 * HALF) @(negedge clk);

    // R10: mid-half parameter change
    cur_req = "R10";
    wait_cnt(5);
    res_dly = 4'd4; dead_len = 4'd6; blank_len = 4'd1;
    wait_cnt(12);
    check("R10", "old ceiling kept this half", int'(ls_a || ls_b), 1);
    repeat (3 * HALF) @(negedge clk);

    // R11: stop and restart
    cur_req = "R11";
    wait_cnt(9);
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11", "all low after stop", int'({hs_a, hs_b, ls_a, ls_b, sr_0, sr_1}), 0);
    repeat (3) @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11", "restart in half 0", int'(hs_a), 1);
    repeat (2 * HALF) @(negedge clk);

    // R3/R8 corner: zero delay, zero blank, zero dead
    cur_req = "R3/R8";
    res_dly = 4'd0; blank_len = 4'd0; dead_len = 4'd0;
    repeat (4 * HALF) @(negedge clk);
    trip = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    trip = 1'b0;

    // R4: delay beyond ceiling gives no pulse
    cur_req = "R4";
    res_dly = 4'd15; dead_len = 4'd2;
    repeat (2 * HALF) @(negedge clk);
    wait_cnt(15);
    check("R4", "no pulse past ceiling", int'(ls_a || ls_b), 0);
    repeat (HALF) @(negedge clk);

    // R1: reset while running
    cur_req = "R1";
    rst = 1'b1;
    @(negedge clk);
    check("R1", "reset while running", int'({hs_a, hs_b, ls_a, ls_b, sr_0, sr_1}), 0);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule